// File: doc/BRIEF.md
# Chained Descriptor Copy Engine with Counting Semaphores

The block is the front end of a small co-processor. It has four independent command channels. Each channel reads eight-word descriptors from memory through a word-wide master port that uses a request/acknowledge handshake. A descriptor is carried out as a plain word copy: the engine reads each word from the source address and writes it to the destination address until the byte count is used up. Afterwards it writes a status word back into the descriptor and follows the chain pointer.

Software points a channel at its first descriptor through a 32-bit register port. It then adds credits to that channel's counting semaphore. A descriptor can take one credit when it finishes, so software paces the channel by how many credits it grants. Completion is reported through per-channel flags in a global status register, and the `irq` output is high while any flag is set. Each channel also keeps the error code of its last descriptor.

A descriptor is eight consecutive 32-bit words at byte offsets 0 to 28:

| Offset | Content |
|---|---|
| 0 | link to the next descriptor |
| 4 | control word A |
| 8 | control word B |
| 12 | source address |
| 16 | destination address |
| 20 | byte count |
| 24 | payload |
| 28 | status |

Top module: `desc_cmd_engine`

## Requirements
- R1: After reset the following all read zero: the global flags (0x010), the enable mask (0x020), and every channel's semaphore, status and command pointer. `irq` is low.
- R2: Writing to a channel's semaphore register (channel base + 0x10) adds the low 8 bits of the data to that channel's count. Reading the same address returns the count.
- R3: A descriptor is carried out by exactly this sequence of memory accesses: reads of descriptor words 0 to 5, then a read of source+k followed by a write of that word to destination+k for k = 0, 4, 8 and so on, then a write of the status word (error code, zero-extended) to descriptor+28.
- R4: Writing ones to 0x018 clears the matching global flags.
- R5: A descriptor that ends with control word A bit 0 set, or with an error, sets flag n (bit n of 0x010) for its channel n. `irq` is the OR of those flags.
- R6: A descriptor that ends without error and has control word A bit 1 set takes one credit from its channel's count. With bit 1 clear, the count is unchanged.
- R7: A descriptor with a nonzero link loads the link into the command pointer. The chain then continues only while the count is nonzero. With no credits left, the channel waits until new credits are written.
- R8: A zero link or an error ends the chain. The channel then starts again only after software writes its command pointer (channel base + 0x00), even if credits remain.
- R9: Channel status (channel base + 0x20) holds one of four codes: 0x01 for a descriptor address that is not word aligned (nothing is accessed), 0x02 for a byte count that is not a multiple of 4 (no copy, status is still written), 0x04 for an access that `mem_err` marks bad (copy aborted, status is still written), and 0 otherwise.
- R10: Writing ones to channel base + 0x28 clears the matching bits of that channel's status.
- R11: Channel n starts a descriptor only while bit n of the enable mask (0x020) is set.
- R12: When several channels are ready, they are served round robin, one descriptor at a time, starting after the channel served last. After reset, channel 0 is first.
- R13: When a register write and the end of a descriptor fall in the same cycle, both take effect. Credits written in that cycle add to the count while the descriptor's credit is taken. A flag that is set in the same cycle as a clear write stays set.
- R14: Once `mem_req` is raised, the address, direction and write data stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 12 | register byte address (write and read) |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | memory byte address |
| mem_wdata | output | 32 | memory write data |
| mem_ack | input | 1 | access complete |
| mem_err | input | 1 | access failed, valid with mem_ack |
| mem_rdata | input | 32 | read data, valid with mem_ack |
| irq | output | 1 | any global flag set |

## Verification
Two things can land in the same cycle: the end of a descriptor, and a software register write that touches the same state. The end of a descriptor takes a credit and sets a flag; the register write either adds credits or clears flags. The bench provokes the collision by watching the port for the acknowledge of a descriptor's status write-back. It then issues the register write in the very next cycle, which is the cycle in which the descriptor ends. The results are judged by the count and flag values read back afterwards: for example, one credit added while one is taken leaves the count unchanged, and a flag cleared as it is set still reads one.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int DW     = 32;
  localparam int REG_AW = 12;

  localparam logic [7:0] ERR_ALIGN = 8'h01;
  localparam logic [7:0] ERR_COUNT = 8'h02;
  localparam logic [7:0] ERR_BUS   = 8'h04;

  localparam logic [REG_AW-1:0] A_GFLAG = 12'h010;
  localparam logic [REG_AW-1:0] A_GCLR  = 12'h018;
  localparam logic [REG_AW-1:0] A_CHEN  = 12'h020;
  localparam logic [3:0]        CH_PAGE = 4'h1;

  localparam logic [5:0] O_CMD  = 6'h00;
  localparam logic [5:0] O_SEM  = 6'h10;
  localparam logic [5:0] O_STAT = 6'h20;
  localparam logic [5:0] O_SCLR = 6'h28;

  localparam logic [2:0] LAST_FETCH  = 3'd5;
  localparam logic [DW-1:0] STAT_OFS = 32'd28;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_STAT, S_DONE
  } eng_state_e;

  typedef struct packed {
    logic [7:0]    code;
    logic          irq;
    logic          dec;
    logic          last;
    logic [DW-1:0] link;
  } done_info_t;
endpackage

// File: rtl/dce_rr_arb.sv
module dce_rr_arb #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         req,
  input  logic                   take,
  output logic                   any,
  output logic [$clog2(NCH)-1:0] idx
);
  localparam int CHW = $clog2(NCH);

  logic [CHW-1:0] last_q;

  always_comb begin
    any = 1'b0;
    idx = last_q;
    for (int k = 1; k <= NCH; k++) begin
      int c;
      c = (int'(last_q) + k) % NCH;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = CHW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= CHW'(NCH - 1);
    else if (take) last_q <= idx;
  end
endmodule

// File: rtl/dce_chan.sv
module dce_chan import dce_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr_cmd,
  input  logic             wr_sem,
  input  logic             wr_clr,
  input  logic [DW-1:0]    wdata,
  input  logic             done,
  input  done_info_t       info,
  output logic [DW-1:0]    cmd_ptr,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       status,
  output logic             ready
);
  logic [DW-1:0]    cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       stat_q, stat_d;
  logic             armed_q, armed_d;
  logic             upd;

  assign upd = wr_cmd | wr_sem | wr_clr | done;

  always_comb begin
    cmd_d   = cmd_q;
    armed_d = armed_q;
    stat_d  = stat_q;
    if (wr_clr) stat_d = stat_q & ~wdata[7:0];
    if (done) begin
      stat_d = info.code;
      if (info.last) armed_d = 1'b0;
      else           cmd_d   = info.link;
    end
    if (wr_cmd) begin
      cmd_d   = wdata;
      armed_d = 1'b1;
    end
    cnt_d = cnt_q + (wr_sem ? wdata[CNT_W-1:0] : '0) - CNT_W'(done && info.dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      cnt_q   <= '0;
      stat_q  <= '0;
      armed_q <= 1'b0;
    end else if (upd) begin
      cmd_q   <= cmd_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      armed_q <= armed_d;
    end
  end

  assign cmd_ptr = cmd_q;
  assign count   = cnt_q;
  assign status  = stat_q;
  assign ready   = enable & armed_q & (cnt_q != '0);
endmodule

// File: rtl/dce_engine.sv
module dce_engine import dce_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(NCH)-1:0] start_ch,
  input  logic [DW-1:0]          start_addr,
  output logic                   idle,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [DW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_ack,
  input  logic                   mem_err,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   done,
  output logic [$clog2(NCH)-1:0] done_ch,
  output done_info_t             info
);
  localparam int CHW = $clog2(NCH);

  eng_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [2:0]     idx_q, idx_d;
  logic [1:0]     ctl_q, ctl_d;
  logic [7:0]     code_q, code_d;
  logic [DW-1:0]  base_q, base_d, link_q, link_d, src_q, src_d;
  logic [DW-1:0]  dst_q, dst_d, len_q, len_d, off_q, off_d, buf_q, buf_d;
  logic           ld;

  assign ld = (state_q != S_IDLE) | start;

  always_comb begin
    state_d = state_q;  ch_d  = ch_q;   idx_d  = idx_q;  ctl_d = ctl_q;
    code_d  = code_q;   base_d = base_q; link_d = link_q; src_d = src_q;
    dst_d   = dst_q;    len_d = len_q;  off_d  = off_q;  buf_d = buf_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; done = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        ch_d = start_ch; base_d = start_addr; link_d = '0; ctl_d = '0;
        idx_d = '0; off_d = '0; code_d = '0;
        if (start_addr[1:0] != 2'b00) begin
          code_d  = ERR_ALIGN;
          state_d = S_DONE;
        end else state_d = S_FETCH;
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + {27'd0, idx_q, 2'b00};
        if (mem_ack) begin
          if (mem_err) begin
            code_d = ERR_BUS; state_d = S_STAT;
          end else begin
            case (idx_q)
              3'd0: link_d = mem_rdata;
              3'd1: ctl_d  = mem_rdata[1:0];
              3'd3: src_d  = mem_rdata;
              3'd4: dst_d  = mem_rdata;
              3'd5: len_d  = mem_rdata;
              default: ;
            endcase
            idx_d = idx_q + 3'd1;
            if (idx_q == LAST_FETCH) state_d = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (len_q[1:0] != 2'b00) begin
          code_d = ERR_COUNT; state_d = S_STAT;
        end else if (len_q == '0) state_d = S_STAT;
        else                      state_d = S_RD;
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_q + off_q;
        if (mem_ack) begin
          if (mem_err) begin
            code_d = ERR_BUS; state_d = S_STAT;
          end else begin
            buf_d = mem_rdata; state_d = S_WR;
          end
        end
      end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = dst_q + off_q; mem_wdata = buf_q;
        if (mem_ack) begin
          if (mem_err) begin
            code_d = ERR_BUS; state_d = S_STAT;
          end else begin
            off_d   = off_q + 32'd4;
            state_d = (off_q + 32'd4 == len_q) ? S_STAT : S_RD;
          end
        end
      end
      S_STAT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = base_q + STAT_OFS; mem_wdata = {24'd0, code_q};
        if (mem_ack) state_d = S_DONE;
      end
      S_DONE: begin
        done = 1'b1; state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; ch_q <= '0; idx_q <= '0; ctl_q <= '0; code_q <= '0;
      base_q <= '0; link_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
      off_q <= '0; buf_q <= '0;
    end else if (ld) begin
      state_q <= state_d; ch_q <= ch_d; idx_q <= idx_d; ctl_q <= ctl_d; code_q <= code_d;
      base_q <= base_d; link_q <= link_d; src_q <= src_d; dst_q <= dst_d; len_q <= len_d;
      off_q <= off_d; buf_q <= buf_d;
    end
  end

  assign idle      = (state_q == S_IDLE);
  assign done_ch   = ch_q;
  assign info.code = code_q;
  assign info.irq  = ctl_q[0] | (code_q != 8'd0);
  assign info.dec  = ctl_q[1] & (code_q == 8'd0);
  assign info.last = (code_q != 8'd0) | (link_q == '0);
  assign info.link = link_q;
endmodule

// File: rtl/desc_cmd_engine.sv
module desc_cmd_engine import dce_pkg::*; #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0]            en_q, gflag_q, gflag_d, ready, ch_done, set_vec;
  logic [NCH-1:0][DW-1:0]    cmd_ptr;
  logic [NCH-1:0][CNT_W-1:0] sem_cnt;
  logic [NCH-1:0][7:0]       ch_stat;
  logic                      arb_any, eng_idle, eng_start, eng_done, done_irq;
  logic [CHW-1:0]            arb_idx, eng_done_ch;
  done_info_t                eng_info;
  logic                      in_page, gclr_wr, en_wr;

  assign in_page = (reg_addr[11:8] == CH_PAGE);
  assign gclr_wr = reg_wr && (reg_addr == A_GCLR);
  assign en_wr   = reg_wr && (reg_addr == A_CHEN);

  dce_rr_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ready), .take(eng_start),
    .any(arb_any), .idx(arb_idx)
  );

  assign eng_start = eng_idle & arb_any;

  dce_engine #(.NCH(NCH)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .start_ch(arb_idx),
    .start_addr(cmd_ptr[arb_idx]), .idle(eng_idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .done(eng_done), .done_ch(eng_done_ch), .info(eng_info)
  );

  assign done_irq = eng_info.irq;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel        = reg_wr && in_page && (reg_addr[7:6] == 2'(n));
    assign ch_done[n] = eng_done && (eng_done_ch == CHW'(n));
    assign set_vec[n] = ch_done[n] && eng_info.irq;
    dce_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .enable(en_q[n]),
      .wr_cmd(sel && reg_addr[5:0] == O_CMD),
      .wr_sem(sel && reg_addr[5:0] == O_SEM),
      .wr_clr(sel && reg_addr[5:0] == O_SCLR),
      .wdata(reg_wdata), .done(ch_done[n]), .info(eng_info),
      .cmd_ptr(cmd_ptr[n]), .count(sem_cnt[n]), .status(ch_stat[n]), .ready(ready[n])
    );
  end

  assign gflag_d = (gflag_q & ~(gclr_wr ? reg_wdata[NCH-1:0] : '0)) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gflag_q <= '0;
      en_q    <= '0;
    end else begin
      if (gclr_wr || eng_done) gflag_q <= gflag_d;
      if (en_wr)               en_q    <= reg_wdata[NCH-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GFLAG) reg_rdata[NCH-1:0] = gflag_q;
    if (reg_addr == A_CHEN)  reg_rdata[NCH-1:0] = en_q;
    for (int n = 0; n < NCH; n++) begin
      if (in_page && reg_addr[7:6] == 2'(n)) begin
        if (reg_addr[5:0] == O_CMD)  reg_rdata = cmd_ptr[n];
        if (reg_addr[5:0] == O_SEM)  reg_rdata[CNT_W-1:0] = sem_cnt[n];
        if (reg_addr[5:0] == O_STAT) reg_rdata[7:0] = ch_stat[n];
      end
    end
  end

  assign irq = |gflag_q;
endmodule

// File: rtl/dce_checker.sv
module dce_checker import dce_pkg::*; #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [REG_AW-1:0]      reg_addr,
  input logic [DW-1:0]          reg_wdata,
  input logic                   mem_req,
  input logic                   mem_ack,
  input logic                   mem_we,
  input logic [DW-1:0]          mem_addr,
  input logic [DW-1:0]          mem_wdata,
  input logic                   irq,
  input logic                   done,
  input logic [$clog2(NCH)-1:0] done_ch,
  input logic                   done_irq,
  input logic [NCH-1:0]         gflag,
  input logic                   start,
  input logic [$clog2(NCH)-1:0] start_ch,
  input logic [NCH-1:0]         en,
  input logic [CNT_W-1:0]       sem0
);
  logic [NCH-1:0] done_oh;
  assign done_oh = NCH'(1) << done_ch;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R14
  AST_GCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_GCLR && reg_wdata[NCH-1:0] == '1 && !done |=> !irq); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_irq |=> (gflag & $past(done_oh)) != '0); // R5
  AST_START_EN: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> en[start_ch]); // R11
  AST_SEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr && !done |=> $stable(sem0)); // R6
endmodule

bind desc_cmd_engine dce_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .irq(irq), .done(eng_done), .done_ch(eng_done_ch),
  .done_irq(done_irq), .gflag(gflag_q), .start(eng_start), .start_ch(arb_idx),
  .en(en_q), .sem0(sem_cnt[0])
);

// File: tb/desc_cmd_engine_tb.sv
module desc_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, mem_req, mem_we, mem_ack, mem_err, irq;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;

  desc_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { logic [31:0] a; logic w; logic [31:0] d; } acc_t;
  acc_t        expq[$];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] err_addr;
  int          checks, errors;
  logic        pend, pw;
  logic [31:0] pa, pd;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  function automatic logic [11:0] chb(input int n);
    return 12'h100 + 12'(n * 'h40);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one acknowledge cycle after each request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_err   <= (mem_addr == err_addr);
      mem_rdata <= mrd(mem_addr);
      if (mem_we && mem_addr != err_addr) mem[mem_addr >> 2] = mem_wdata;
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
  end

  // reference access sequence compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) chk(mem_req && mem_addr == pa && mem_we == pw && mem_wdata == pd,
                    "R14 request held", mem_addr, pa);
      pend = mem_req && !mem_ack;
      pa = mem_addr; pw = mem_we; pd = mem_wdata;
      if (mem_req && mem_ack) begin
        if (expq.size() == 0) chk(1'b0, "R3 unexpected access", mem_addr, 32'hffffffff);
        else begin
          acc_t e;
          e = expq.pop_front();
          chk(mem_addr == e.a && mem_we == e.w && (!e.w || mem_wdata == e.d),
              e.w ? "R3 write access" : "R3 read access", e.w ? mem_wdata : mem_addr,
              e.w ? e.d : e.a);
        end
      end
    end else pend = 1'b0;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] link, input logic [31:0] ctl,
                          input logic [31:0] src, input logic [31:0] dst, input logic [31:0] len);
    mem[b >> 2] = link; mem[(b >> 2) + 1] = ctl; mem[(b >> 2) + 2] = 32'h0;
    mem[(b >> 2) + 3] = src; mem[(b >> 2) + 4] = dst; mem[(b >> 2) + 5] = len;
    mem[(b >> 2) + 6] = 32'h0; mem[(b >> 2) + 7] = 32'hffffffff;
  endtask

  task automatic exp_fetch(input logic [31:0] b);
    for (int i = 0; i < 6; i++) expq.push_back('{b + 32'(4 * i), 1'b0, 32'h0});
  endtask

  task automatic exp_copy(input logic [31:0] src, input logic [31:0] dst, input int nw);
    for (int i = 0; i < nw; i++) begin
      expq.push_back('{src + 32'(4 * i), 1'b0, 32'h0});
      expq.push_back('{dst + 32'(4 * i), 1'b1, mrd(src + 32'(4 * i))});
    end
  endtask

  task automatic exp_stat(input logic [31:0] b, input logic [31:0] code);
    expq.push_back('{b + 32'd28, 1'b1, code});
  endtask

  task automatic exp_ok(input logic [31:0] b, input logic [31:0] src, input logic [31:0] dst, input int nw);
    exp_fetch(b); exp_copy(src, dst, nw); exp_stat(b, 32'h0);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (expq.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, tag, 32'(expq.size()), 32'h0);
  endtask

  task automatic collide(input logic [31:0] stat_addr, input logic [11:0] a, input logic [31:0] d);
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(mem_req && mem_ack && mem_we && mem_addr == stat_addr) && n < 5000);
    wr(a, d);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    checks = 0; errors = 0; pend = 1'b0; err_addr = 32'hffffffff;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      mem[(32'h2000 >> 2) + i] = 32'ha0000000 + 32'(i);
      mem[(32'h2100 >> 2) + i] = 32'hb0000000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
    rd_chk(12'h010, 32'h0, "R1 global flags");
    rd_chk(12'h020, 32'h0, "R1 enable mask");
    rd_chk(chb(0) + 12'h10, 32'h0, "R1 semaphore");
    rd_chk(chb(0) + 12'h20, 32'h0, "R1 channel status");
    rd_chk(chb(3) + 12'h00, 32'h0, "R1 command pointer");

    // R2 semaphore accumulates; R11 nothing runs while disabled
    put_desc(32'h1000, 32'h0, 32'h3, 32'h2000, 32'h3000, 32'd12);
    wr(chb(0), 32'h1000);
    wr(chb(0) + 12'h10, 32'd3);
    wr(chb(0) + 12'h10, 32'd2);
    rd_chk(chb(0) + 12'h10, 32'd5, "R2 semaphore sum");
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R11 disabled channel idle", 32'h0, 32'h0);
    exp_ok(32'h1000, 32'h2000, 32'h3000, 3);
    wr(12'h020, 32'h1);
    wait_idle("R11 enabled channel ran");
    for (int i = 0; i < 3; i++)
      chk(mrd(32'h3000 + 32'(4 * i)) == 32'ha0000000 + 32'(i), "R3 copied word",
          mrd(32'h3000 + 32'(4 * i)), 32'ha0000000 + 32'(i));
    chk(mrd(32'h101c) == 32'h0, "R3 status write-back", mrd(32'h101c), 32'h0);
    rd_chk(chb(0) + 12'h10, 32'd4, "R6 credit taken");
    rd_chk(12'h010, 32'h1, "R5 flag set");
    chk(irq == 1'b1, "R5 irq high", 32'(irq), 32'h1);
    rd_chk(chb(0), 32'h1000, "R8 zero link keeps pointer");

    // R4 global clear
    wr(12'h018, 32'h1);
    rd_chk(12'h010, 32'h0, "R4 flag cleared");
    chk(irq == 1'b0, "R4 irq low", 32'(irq), 32'h0);

    // R8 re-arm by pointer write; R6/R5 no credit taken, no flag
    put_desc(32'h1000, 32'h0, 32'h0, 32'h2000, 32'h3000, 32'd4);
    exp_ok(32'h1000, 32'h2000, 32'h3000, 1);
    wr(chb(0), 32'h1000);
    wait_idle("R8 re-armed run");
    rd_chk(chb(0) + 12'h10, 32'd4, "R6 count unchanged");
    rd_chk(12'h010, 32'h0, "R5 no flag without request");

    // R7 chain paced by credits
    put_desc(32'h1100, 32'h1140, 32'h3, 32'h2000, 32'h3200, 32'd8);
    put_desc(32'h1140, 32'h0, 32'h3, 32'h2010, 32'h3240, 32'd4);
    wr(12'h020, 32'h3);
    wr(chb(1), 32'h1100);
    exp_ok(32'h1100, 32'h2000, 32'h3200, 2);
    wr(chb(1) + 12'h10, 32'd1);
    wait_idle("R7 first link only");
    rd_chk(chb(1), 32'h1140, "R7 link loaded");
    rd_chk(chb(1) + 12'h10, 32'd0, "R7 credits used");
    exp_ok(32'h1140, 32'h2010, 32'h3240, 1);
    wr(chb(1) + 12'h10, 32'd1);
    wait_idle("R7 resumes on credit");
    chk(mrd(32'h3240) == 32'ha0000004, "R7 second copy", mrd(32'h3240), 32'ha0000004);
    rd_chk(12'h010, 32'h2, "R5 channel 1 flag");
    wr(12'h018, 32'hf);

    // R9 error codes on channel 2
    wr(12'h020, 32'h7);
    wr(chb(2), 32'h1203);
    wr(chb(2) + 12'h10, 32'd1);
    wait_idle("R9 unaligned makes no access");
    rd_chk(chb(2) + 12'h20, 32'h01, "R9 alignment code");
    rd_chk(12'h010, 32'h4, "R5 flag on error");
    rd_chk(chb(2) + 12'h10, 32'd1, "R6 no credit on error");
    wr(chb(2) + 12'h28, 32'hff);
    rd_chk(chb(2) + 12'h20, 32'h0, "R10 status cleared");
    wr(12'h018, 32'hf);

    put_desc(32'h1200, 32'h0, 32'h2, 32'h2000, 32'h3300, 32'd6);
    exp_fetch(32'h1200); exp_stat(32'h1200, 32'h2);
    wr(chb(2), 32'h1200);
    wait_idle("R9 bad count run");
    rd_chk(chb(2) + 12'h20, 32'h02, "R9 count code");
    chk(mrd(32'h121c) == 32'h2, "R9 count code written", mrd(32'h121c), 32'h2);
    rd_chk(12'h010, 32'h4, "R5 flag on count error");
    wr(chb(2) + 12'h28, 32'hff);

    put_desc(32'h1240, 32'h0, 32'h2, 32'h2000, 32'h3340, 32'd8);
    err_addr = 32'h2004;
    exp_fetch(32'h1240); exp_copy(32'h2000, 32'h3340, 1);
    expq.push_back('{32'h2004, 1'b0, 32'h0}); exp_stat(32'h1240, 32'h4);
    wr(chb(2), 32'h1240);
    wait_idle("R9 bus error run");
    err_addr = 32'hffffffff;
    rd_chk(chb(2) + 12'h20, 32'h04, "R9 bus code");
    chk(mrd(32'h125c) == 32'h4, "R9 bus code written", mrd(32'h125c), 32'h4);
    rd_chk(chb(2) + 12'h10, 32'd1, "R8 error ends chain");
    wr(12'h018, 32'hf);

    // R12 round robin, last served was channel 2
    wr(12'h020, 32'h0);
    put_desc(32'h1300, 32'h1340, 32'h2, 32'h2100, 32'h3400, 32'd4);
    put_desc(32'h1340, 32'h0,    32'h2, 32'h2104, 32'h3404, 32'd4);
    put_desc(32'h1380, 32'h13c0, 32'h2, 32'h2108, 32'h3408, 32'd4);
    put_desc(32'h13c0, 32'h0,    32'h2, 32'h210c, 32'h340c, 32'd4);
    wr(chb(1), 32'h1300); wr(chb(1) + 12'h10, 32'd2);
    wr(chb(3), 32'h1380); wr(chb(3) + 12'h10, 32'd2);
    exp_ok(32'h1380, 32'h2108, 32'h3408, 1);
    exp_ok(32'h1300, 32'h2100, 32'h3400, 1);
    exp_ok(32'h13c0, 32'h210c, 32'h340c, 1);
    exp_ok(32'h1340, 32'h2104, 32'h3404, 1);
    wr(12'h020, 32'hf);
    wait_idle("R12 alternating order");
    rd_chk(chb(1) + 12'h10, 32'd0, "R12 channel 1 credits");
    rd_chk(chb(3) + 12'h10, 32'd0, "R12 channel 3 credits");

    // R13 credit write in the ending cycle
    put_desc(32'h1400, 32'h0, 32'h3, 32'h2000, 32'h3500, 32'd4);
    wr(chb(1), 32'h1400);
    exp_ok(32'h1400, 32'h2000, 32'h3500, 1);
    wr(chb(1) + 12'h10, 32'd1);
    collide(32'h141c, chb(1) + 12'h10, 32'd1);
    wait_idle("R13 credit collision run");
    rd_chk(chb(1) + 12'h10, 32'd1, "R13 add and take together");
    wr(12'h018, 32'hf);
    rd_chk(12'h010, 32'h0, "R4 all cleared");

    // R13 flag clear in the setting cycle
    exp_ok(32'h1400, 32'h2000, 32'h3500, 1);
    wr(chb(1), 32'h1400);
    collide(32'h141c, 12'h018, 32'h2);
    wait_idle("R13 flag collision run");
    rd_chk(12'h010, 32'h2, "R13 set wins over clear");
    rd_chk(chb(1) + 12'h10, 32'd0, "R6 last credit taken");

    summary();
  end
endmodule